// File: doc/BRIEF.md
# Frame save/restore sequencer with stack canary

The block carries out one frame-save (store-multiple) or frame-restore (load-multiple) instruction. It turns the instruction into a series of single-word stack accesses. A start pulse supplies several inputs together: the decoded instruction fields, the direction, the current stack pointer, a canary base value and a canary enable bit. The base is a value captured once at program start, for example a free-running counter snapshot. The sequencer reads source registers through one register-file read port and writes restored registers through one write port. It moves data over a request/ready memory interface and reports completion together with the final stack pointer.

A frame may hold the link register, the global pointer, a contiguous range of general registers and a protective canary word. The canary is the base value XORed with the address of the stack slot that holds it. Frames that reuse the same save/restore sequence therefore still carry distinct canaries. A restore loads and checks the canary before it writes any register. On a mismatch the restore aborts and raises a sticky fault.

Top module: `lsm_seq`

## Requirements
- R1: The 15-bit instruction word has these fields: bits [5:0] lower range bound, bits [11:6] upper range bound, bit 12 save-link flag, bit 13 save-global-pointer flag, bit 14 canary flag. `op_i` selects the direction: 0 means save, 1 means restore.
- R2: A save pushes, in this order: the link register (register 1, if its flag is set), the global pointer (register 3, if its flag is set), registers lower bound up to upper bound in ascending order, and the canary (if active). A save never writes the register file.
- R3: Range registers are moved only when the upper bound is greater than or equal to the lower bound. Otherwise the range is skipped.
- R4: The stack grows downward in 8-byte words. Each push writes at the stack pointer minus 8 and lowers the pointer by 8. Each pop reads at the stack pointer and raises it by 8.
- R5: The canary word is the canary base XOR the address of the slot that holds it.
- R6: A restore pops in exact reverse order: canary, registers upper bound down to lower bound, global pointer, link register. Each popped word is written to its register.
- R7: If the restored canary differs from the expected value, `fault_o` rises. No register write and no further memory access occurs, `sp_o` keeps its previous value, and `fault_o` stays high until `fault_ack_i`.
- R8: When `canary_en_i` is low, the canary flag is ignored on both save and restore: no slot is written, read or checked.
- R9: Each access is one request whose address and direction stay stable until `mem_ready_i`. At most one access is accepted per cycle, and every instruction completes.
- R10: An instruction with no active flags and upper bound below lower bound raises `done_o` one cycle after start, makes no memory access, and reports `sp_o` equal to the incoming stack pointer.
- R11: `sp_o` changes only together with `done_o`. `done_o` is a one-cycle pulse.
- R12: After reset the block is idle: no request, no done, no fault, `sp_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction (ignored while busy) |
| op_i | input | 1 | 0 save, 1 restore |
| instr_i | input | 15 | Decoded instruction fields |
| sp_i | input | 64 | Stack pointer at start |
| canary_base_i | input | 64 | Program canary base |
| canary_en_i | input | 1 | Canary enable control bit |
| rf_raddr_o | output | 6 | Register file read index |
| rf_rdata_i | input | 64 | Register file read data (combinational) |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 6 | Register file write index |
| rf_wdata_o | output | 64 | Register file write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Word address (byte units) |
| mem_wdata_o | output | 64 | Write data |
| mem_ready_i | input | 1 | Access accepted this cycle |
| mem_rdata_i | input | 64 | Read data, valid with ready |
| busy_o | output | 1 | Instruction in progress or fault pending |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Canary fault, held until acknowledged |
| fault_ack_i | input | 1 | Clears a pending fault |
| sp_o | output | 64 | Final stack pointer |

## Verification
The hardest state to reach is a restore whose canary slot has been overwritten. This happens only after a save has laid down a frame with the canary active and something has then altered memory. The stimulus runs save/restore pairs against a bench memory model. In a random subset of pairs it flips one bit of the canary slot between the two halves. It then holds the fault for several cycles before acknowledging it. Memory ready is randomly withheld so that requests are stretched across several cycles. The directed cases cover an empty instruction, a single-register range, an inverted range with flags set, and a set canary flag while the enable bit is low.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int RIDX_W  = 6;
  localparam int INSTR_W = 2 * RIDX_W + 3;
  localparam int NPH     = 4;

  typedef struct packed {
    logic              can;
    logic              gp;
    logic              lr;
    logic [RIDX_W-1:0] hi;
    logic [RIDX_W-1:0] lo;
  } lsm_instr_t;

  // Values 0..3 are also the save-order position of each step
  typedef enum logic [2:0] {
    PH_LR    = 3'd0,
    PH_GP    = 3'd1,
    PH_RNG   = 3'd2,
    PH_CAN   = 3'd3,
    PH_IDLE  = 3'd4,
    PH_FAULT = 3'd5
  } phase_e;
endpackage

// File: rtl/lsm_step_pick.sv
module lsm_step_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]         en_i,
  input  logic                 rev_i,
  input  logic                 from_start_i,
  input  logic [$clog2(N)-1:0] cur_i,
  output logic                 has_next_o,
  output logic [$clog2(N)-1:0] next_o
);
  localparam int IW = $clog2(N);

  // Next enabled step after cur_i, walking forward for save and backward for restore
  always_comb begin
    int cp;
    has_next_o = 1'b0;
    next_o     = '0;
    cp = rev_i ? (N - 1 - int'(cur_i)) : int'(cur_i);
    for (int j = 0; j < N; j++) begin
      int p;
      p = rev_i ? (N - 1 - j) : j;
      if (!has_next_o && en_i[p] && (from_start_i || j > cp)) begin
        has_next_o = 1'b1;
        next_o     = p[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/lsm_range_ctr.sv
module lsm_range_ctr #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic         init_down_i,
  input  logic [W-1:0] init_val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  input  logic         step_i,
  input  logic         active_i,
  output logic [W-1:0] ptr_o,
  output logic         last_o
);
  logic [W-1:0] ptr_q;
  logic         down_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      down_q <= 1'b0;
    end else if (init_i) begin
      ptr_q  <= init_val_i;
      down_q <= init_down_i;
    end else if (step_i) begin
      ptr_q  <= down_q ? ptr_q - 1'b1 : ptr_q + 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign last_o = down_q ? (ptr_q == lo_i) : (ptr_q == hi_i);

  // R3
  range_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (ptr_q >= lo_i && ptr_q <= hi_i));
endmodule

// File: rtl/lsm_canary.sv
module lsm_canary #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] slot_i,
  input  logic [XLEN-1:0] rdata_i,
  output logic [XLEN-1:0] canary_o,
  output logic            match_o
);
  assign canary_o = base_i ^ slot_i;
  assign match_o  = (rdata_i == canary_o);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
  import lsm_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int LR_IDX = 1,
  parameter int GP_IDX = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               op_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [XLEN-1:0]    sp_i,
  input  logic [XLEN-1:0]    canary_base_i,
  input  logic               canary_en_i,
  output logic [RIDX_W-1:0]  rf_raddr_o,
  input  logic [XLEN-1:0]    rf_rdata_i,
  output logic               rf_we_o,
  output logic [RIDX_W-1:0]  rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [XLEN-1:0]    mem_addr_o,
  output logic [XLEN-1:0]    mem_wdata_o,
  input  logic               mem_ready_i,
  input  logic [XLEN-1:0]    mem_rdata_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  input  logic               fault_ack_i,
  output logic [XLEN-1:0]    sp_o
);
  localparam int              WB   = XLEN / 8;
  localparam logic [XLEN-1:0] STEP = XLEN'(WB);
  localparam int              PW   = $clog2(NPH);

  lsm_instr_t ins;
  assign ins = lsm_instr_t'(instr_i);

  phase_e            phase_q;
  logic              is_load_q;
  logic [NPH-1:0]    mask_q;
  logic [RIDX_W-1:0] lo_q, hi_q;
  logic [XLEN-1:0]   sp_q, base_q, sp_out_q;
  logic              done_q;

  logic              idle, active, in_rng, fire, adv, can_bad;
  logic [NPH-1:0]    en_new;
  logic              has_next;
  logic [PW-1:0]     nxt;
  logic [RIDX_W-1:0] ptr;
  logic              rng_last;
  logic [XLEN-1:0]   acc_addr, sp_nxt, canary;
  logic              can_match;

  assign idle   = (phase_q == PH_IDLE);
  assign active = ~phase_q[2];
  assign in_rng = (phase_q == PH_RNG);
  assign fire   = active & mem_ready_i;

  // Step enables indexed by save position: link, global pointer, range, canary
  assign en_new = {ins.can & canary_en_i, ins.hi >= ins.lo, ins.gp, ins.lr};

  lsm_step_pick #(.N(NPH)) u_pick (
    .en_i        (idle ? en_new : mask_q),
    .rev_i       (idle ? op_i : is_load_q),
    .from_start_i(idle),
    .cur_i       (phase_q[PW-1:0]),
    .has_next_o  (has_next),
    .next_o      (nxt)
  );

  lsm_range_ctr #(.W(RIDX_W)) u_rng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (idle & start_i),
    .init_down_i(op_i),
    .init_val_i (op_i ? ins.hi : ins.lo),
    .lo_i       (lo_q),
    .hi_i       (hi_q),
    .step_i     (fire & in_rng & ~rng_last),
    .active_i   (in_rng),
    .ptr_o      (ptr),
    .last_o     (rng_last)
  );

  assign acc_addr = is_load_q ? sp_q : sp_q - STEP;
  assign sp_nxt   = is_load_q ? sp_q + STEP : sp_q - STEP;

  lsm_canary #(.XLEN(XLEN)) u_can (
    .base_i  (base_q),
    .slot_i  (acc_addr),
    .rdata_i (mem_rdata_i),
    .canary_o(canary),
    .match_o (can_match)
  );

  assign adv     = fire & (~in_rng | rng_last);
  assign can_bad = is_load_q & (phase_q == PH_CAN) & ~can_match;

  always_comb begin
    case (phase_q)
      PH_LR:   rf_raddr_o = RIDX_W'(LR_IDX);
      PH_GP:   rf_raddr_o = RIDX_W'(GP_IDX);
      PH_RNG:  rf_raddr_o = ptr;
      default: rf_raddr_o = '0;
    endcase
  end

  assign mem_req_o   = active;
  assign mem_we_o    = active & ~is_load_q;
  assign mem_addr_o  = acc_addr;
  assign mem_wdata_o = (phase_q == PH_CAN) ? canary : rf_rdata_i;

  assign rf_we_o    = fire & is_load_q & (phase_q != PH_CAN);
  assign rf_waddr_o = rf_raddr_o;
  assign rf_wdata_o = mem_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      is_load_q <= 1'b0;
      mask_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      sp_q      <= '0;
      base_q    <= '0;
      sp_out_q  <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          is_load_q <= op_i;
          mask_q    <= en_new;
          lo_q      <= ins.lo;
          hi_q      <= ins.hi;
          sp_q      <= sp_i;
          base_q    <= canary_base_i;
          if (has_next) phase_q <= phase_e'({1'b0, nxt});
          else begin
            done_q   <= 1'b1;
            sp_out_q <= sp_i;
          end
        end
        PH_FAULT: if (fault_ack_i) phase_q <= PH_IDLE;
        default: if (fire) begin
          if (can_bad) phase_q <= PH_FAULT;
          else begin
            sp_q <= sp_nxt;
            if (adv) begin
              if (has_next) phase_q <= phase_e'({1'b0, nxt});
              else begin
                phase_q  <= PH_IDLE;
                done_q   <= 1'b1;
                sp_out_q <= sp_nxt;
              end
            end
          end
        end
      endcase
    end
  end

  assign busy_o  = ~idle;
  assign done_o  = done_q;
  assign fault_o = (phase_q == PH_FAULT);
  assign sp_o    = sp_out_q;

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  // R7
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !rf_we_o && !mem_req_o);
  // R7
  fault_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !fault_ack_i |=> fault_o);
  // R11
  sp_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_o) |-> done_o);
  // R2
  save_no_rf_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !rf_we_o);
endmodule

// File: tb/lsm_seq_bench.sv
`timescale 1ns/1ps
module lsm_seq_bench;
  localparam int LR = 1;
  localparam int GP = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op = 1'b0, en = 1'b0, fault_ack = 1'b0;
  logic [14:0] instr = '0;
  logic [63:0] sp_in = '0, base = '0;
  logic [5:0]  rf_raddr, rf_waddr;
  logic [63:0] rf_rdata, rf_wdata, mem_addr, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        rf_we, mem_req, mem_we, busy, done, fault;
  logic        mem_ready = 1'b0;
  logic [63:0] sp_out;

  logic [63:0] rf  [64];
  logic [63:0] mem [512];
  assign rf_rdata = rf[rf_raddr];

  int n_chk = 0, n_fail = 0, cyc_all = 0;
  logic [63:0] t_addr [128]; logic t_we [128]; logic [63:0] t_data [128]; int t_n = 0;
  logic [5:0]  w_reg  [128]; logic [63:0] w_data [128]; int w_n = 0;
  logic [63:0] e_addr [128]; logic e_we [128]; logic [63:0] e_data [128]; int e_n = 0;
  logic [5:0]  ew_reg [128]; logic [63:0] ew_data [128]; int ew_n = 0;
  logic hold_err = 1'b0, prev_wait = 1'b0;
  logic [63:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  lsm_seq u_lsm_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .instr_i(instr),
    .sp_i(sp_in), .canary_base_i(base), .canary_en_i(en),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .fault_o(fault), .fault_ack_i(fault_ack),
    .sp_o(sp_out)
  );

  function automatic int idx(input logic [63:0] a);
    return int'(a[11:3]);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model: ready withheld at random, handshake and writes recorded mid-cycle
  always @(negedge clk) begin
    mem_ready = mem_req && ($urandom % 3 != 0);
    mem_rdata = mem[idx(mem_addr)];
    #1;
    if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err = 1'b1;
    prev_wait = mem_req && !mem_ready;
    prev_addr = mem_addr;
    if (mem_req && mem_ready && t_n < 128) begin
      t_addr[t_n] = mem_addr; t_we[t_n] = mem_we; t_data[t_n] = mem_wdata;
      if (mem_we) mem[idx(mem_addr)] = mem_wdata;
      t_n++;
    end
    if (rf_we && w_n < 128) begin
      w_reg[w_n] = rf_waddr; w_data[w_n] = rf_wdata;
      rf[rf_waddr] = rf_wdata;
      w_n++;
    end
  end

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc_all);
      summary();
      $finish;
    end
  end

  task automatic push_e(input logic [63:0] a, input logic [63:0] d);
    e_addr[e_n] = a; e_we[e_n] = 1'b1; e_data[e_n] = d; e_n++;
  endtask

  task automatic pop_e(input logic [63:0] a, input int r);
    e_addr[e_n] = a; e_we[e_n] = 1'b0; e_data[e_n] = '0; e_n++;
    ew_reg[ew_n] = 6'(r); ew_data[ew_n] = mem[idx(a)]; ew_n++;
  endtask

  task automatic build_store(input logic [14:0] ins, input logic [63:0] sp, input logic ce,
                             output logic [63:0] fin);
    logic [63:0] c;
    c = sp; e_n = 0; ew_n = 0;
    if (ins[12]) begin c -= 64'd8; push_e(c, rf[LR]); end
    if (ins[13]) begin c -= 64'd8; push_e(c, rf[GP]); end
    if (ins[11:6] >= ins[5:0])
      for (int r = int'(ins[5:0]); r <= int'(ins[11:6]); r++) begin c -= 64'd8; push_e(c, rf[r]); end
    if (ins[14] && ce) begin c -= 64'd8; push_e(c, base ^ c); end
    fin = c;
  endtask

  task automatic build_load(input logic [14:0] ins, input logic [63:0] sp, input logic ce,
                            output logic [63:0] fin, output logic flt);
    logic [63:0] c;
    c = sp; e_n = 0; ew_n = 0; flt = 1'b0;
    if (ins[14] && ce) begin
      e_addr[0] = c; e_we[0] = 1'b0; e_data[0] = '0; e_n = 1;
      if (mem[idx(c)] != (base ^ c)) flt = 1'b1;
      c += 64'd8;
    end
    if (!flt) begin
      if (ins[11:6] >= ins[5:0])
        for (int r = int'(ins[11:6]); r >= int'(ins[5:0]); r--) begin pop_e(c, r); c += 64'd8; end
      if (ins[13]) begin pop_e(c, GP); c += 64'd8; end
      if (ins[12]) begin pop_e(c, LR); c += 64'd8; end
    end
    fin = c;
  endtask

  task automatic run_op(input logic ld, input logic [14:0] ins, input logic [63:0] sp,
                        input logic ce, output int cyc, output logic flt);
    t_n = 0; w_n = 0; hold_err = 1'b0;
    @(negedge clk);
    op = ld; instr = ins; sp_in = sp; en = ce; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && !fault && cyc < 5000) begin @(negedge clk); cyc++; end
    flt = fault;
    chk(cyc < 5000, "R9 completion", 64'(cyc), 64'd5000);
    chk(!hold_err, "R9 request hold", 64'(hold_err), 64'd0);
  endtask

  task automatic cmp_trace(input string req);
    chk(t_n == e_n, {req, " access count"}, 64'(t_n), 64'(e_n));
    for (int i = 0; i < t_n && i < e_n; i++) begin
      chk(t_addr[i] == e_addr[i] && t_we[i] == e_we[i], {req, " access addr/dir"}, t_addr[i], e_addr[i]);
      if (e_we[i]) chk(t_data[i] == e_data[i], {req, " pushed word"}, t_data[i], e_data[i]);
    end
    chk(w_n == ew_n, {req, " rf write count"}, 64'(w_n), 64'(ew_n));
    for (int i = 0; i < w_n && i < ew_n; i++)
      chk(w_reg[i] == ew_reg[i] && w_data[i] == ew_data[i], {req, " rf write"}, w_data[i], ew_data[i]);
  endtask

  task automatic rand_rf();
    for (int i = 0; i < 64; i++) rf[i] = {$urandom, $urandom};
  endtask

  task automatic pair(input logic [14:0] ins, input logic [63:0] sp, input logic ce,
                      input bit corrupt, input string tag);
    logic [63:0] fin_s, fin_l;
    logic exp_flt, flt;
    int cyc;
    base = {$urandom, $urandom};
    rand_rf();
    build_store(ins, sp, ce, fin_s);
    run_op(1'b0, ins, sp, ce, cyc, flt);
    chk(!flt, {tag, " R2 save no fault"}, 64'(flt), 64'd0);
    cmp_trace({tag, " R2/R4/R5 save"});
    chk(sp_out == fin_s, {tag, " R4 save sp"}, sp_out, fin_s);
    @(negedge clk);
    chk(!done, {tag, " R11 done pulse"}, 64'(done), 64'd0);
    if (corrupt && ins[14] && ce) mem[idx(fin_s)] ^= 64'h1 << ($urandom % 64);
    rand_rf();
    build_load(ins, fin_s, ce, fin_l, exp_flt);
    run_op(1'b1, ins, fin_s, ce, cyc, flt);
    chk(flt == exp_flt, {tag, " R7 fault flag"}, 64'(flt), 64'(exp_flt));
    cmp_trace({tag, " R6 restore"});
    if (exp_flt) begin
      chk(sp_out == fin_s, {tag, " R7 sp unchanged"}, sp_out, fin_s);
      repeat (3) @(negedge clk);
      chk(fault && w_n == 0 && t_n == 1, {tag, " R7 fault held quiet"}, 64'(w_n), 64'd0);
      fault_ack = 1'b1;
      @(negedge clk);
      fault_ack = 1'b0;
      chk(!fault && !busy, {tag, " R7 fault cleared"}, 64'(fault), 64'd0);
    end else begin
      chk(sp_out == fin_l && fin_l == sp, {tag, " R6/R11 restore sp"}, sp_out, sp);
    end
  endtask

  initial begin
    int cyc;
    logic flt;
    void'($urandom(32'h1a2b3c));
    for (int i = 0; i < 512; i++) mem[i] = '0;
    rand_rf();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12
    chk(!mem_req && !done && !fault && !busy && sp_out == 0, "R12 reset state", sp_out, 64'd0);

    // R10 empty save and restore: inverted range, no flags
    run_op(1'b0, {3'b000, 6'd2, 6'd5}, 64'h1800, 1'b1, cyc, flt);
    chk(cyc == 1 && t_n == 0, "R10 empty save", 64'(cyc), 64'd1);
    chk(sp_out == 64'h1800, "R10 empty sp", sp_out, 64'h1800);
    run_op(1'b1, {3'b000, 6'd0, 6'd63}, 64'h1900, 1'b1, cyc, flt);
    chk(cyc == 1 && t_n == 0 && w_n == 0, "R10 empty restore", 64'(cyc), 64'd1);
    // R8 canary flag alone with enable low is also empty
    run_op(1'b0, {3'b100, 6'd1, 6'd9}, 64'h1a00, 1'b0, cyc, flt);
    chk(cyc == 1 && t_n == 0, "R8 disabled canary only", 64'(t_n), 64'd0);

    // R1 field split with all flags and distinct bounds
    pair({3'b111, 6'd7, 6'd4}, 64'h1800, 1'b1, 1'b0, "R1 full");
    // R3 single register and inverted range with flags
    pair({3'b101, 6'd9, 6'd9}, 64'h1840, 1'b1, 1'b0, "R3 one reg");
    pair({3'b011, 6'd3, 6'd8}, 64'h1880, 1'b1, 1'b0, "R3 inverted");
    // R8 canary flag with enable low
    pair({3'b111, 6'd12, 6'd10}, 64'h1900, 1'b0, 1'b0, "R8 disabled");
    // R7 corrupted canary
    pair({3'b111, 6'd5, 6'd2}, 64'h1a00, 1'b1, 1'b1, "R7 corrupt");
    pair({3'b100, 6'd0, 6'd1}, 64'h1a80, 1'b1, 1'b1, "R7 canary only");
    // Wide range
    pair({3'b111, 6'd63, 6'd0}, 64'h1c00, 1'b1, 1'b0, "R6 all regs");

    for (int k = 0; k < 60; k++) begin
      logic [5:0] lo, hi;
      logic [2:0] fl;
      lo = 6'($urandom % 64);
      if ($urandom % 5 == 0) hi = 6'($urandom % 64);
      else hi = (int'(lo) + int'($urandom % 12) > 63) ? 6'd63 : 6'(int'(lo) + int'($urandom % 12));
      fl = 3'($urandom % 8);
      pair({fl, hi, lo}, 64'h1600 + 64'(($urandom % 64) * 8), ($urandom % 4) != 0,
           ($urandom % 4) == 0, "R2/R6 random");
    end

    summary();
    $finish;
  end
endmodule